// File: doc/BRIEF.md
# Spread-Spectrum Bit-Time Generator

This block marks the bit boundaries of one serial bus channel. It counts a 64 MHz tick, which arrives as a one-cycle enable on the system clock. Each bit period lasts a programmable number of base ticks plus a pseudo-random number of extra ticks. A 3-bit deviation code sets the largest extra delay. Spreading the bit time this way smears the channel's emission spectrum. With spreading turned off, the base count alone gives fine, exact control of the bit rate.

Two internal configuration registers hold the settings: an 8-bit base tick count and a 3-bit deviation code. Both are loaded through a single write strobe with a select bit. Any write stops the current activity, and the new values take effect when the next run is started. A start pulse, given while enable is high, begins a fresh period at once. The output is a one-clock pulse at each bit boundary.

Top module: `ssBitTimer`

## Requirements
- R1: After reset, bitPulse is low, the base count is 40 (0x28) and the deviation code is 0. A start with no prior writes therefore gives periods of exactly 40 ticks.
- R2: Only clock cycles with tick high advance the period. A period of T ticks ends on the clock edge that accepts its T-th tick.
- R3: With deviation code 0, every period lasts exactly B ticks, where B is the base register value. A base value of 0 is treated as 1.
- R4: Deviation codes 1, 2, 3 and 4 allow up to 16, 32, 64 and 78 extra ticks. Every period lies between B and B plus that limit.
- R5: Deviation codes 5, 6 and 7 behave as code 0: no extra ticks.
- R6: The extra tick count is redrawn at every bit boundary. It comes from a 16-bit maximal-length LFSR (x^16+x^14+x^13+x^11+1) and is folded into range with a single compare-and-subtract. With spreading on, consecutive periods therefore vary.
- R7: A start while enable is high restarts at once. The counter is cleared, and the first pulse follows exactly one full period after the start cycle. A start while enable is low is ignored.
- R8: While enable is low, no bitPulse is produced, and the run stays stopped until the next start.
- R9: A write strobe stops the run, with no pulse until the next start. cfgSel 0 writes cfgData[7:0] to the base register; cfgSel 1 writes cfgData[2:0] to the deviation code. The new values govern the periods after the next start.
- R10: When a write and a start arrive in the same cycle, the write takes effect and the start is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 64 MHz time-step enable, one clock wide |
| enable | input | 1 | Channel run enable |
| start | input | 1 | Begin a new period immediately |
| cfgWrite | input | 1 | Configuration write strobe; aborts activity |
| cfgSel | input | 1 | 0 selects base count, 1 selects deviation code |
| cfgData | input | 8 | Write data |
| bitPulse | output | 1 | One-clock pulse at each bit boundary |

## Verification
Some properties are checked by assertions on every cycle. The period counter always stays below its target. The drawn offset never exceeds the limit of the active code, and reserved codes draw nothing. The LFSR never locks up at zero. A write or a dropped enable silences the output on the next cycle, and no pulse appears without a run in progress. Only the directed scenarios can show the actual period lengths: that they are exact for each base and tick rate, that they stay bounded yet varied under each deviation code, and that restarts and aborts behave as required.

// File: rtl/ss_timer_pkg.sv
package ss_timer_pkg;

  localparam int OFF_W = 7;

  typedef struct packed {
    logic load;
    logic step;
    logic wrap;
    logic clear;
  } seqStrobes_t;

  function automatic logic [OFF_W-1:0] devLimit(input logic [2:0] code);
    case (code)
      3'd1:    devLimit = 7'd16;
      3'd2:    devLimit = 7'd32;
      3'd3:    devLimit = 7'd64;
      3'd4:    devLimit = 7'd78;
      default: devLimit = 7'd0;
    endcase
  endfunction

endpackage

// File: rtl/ssLfsr.sv
module ssLfsr #(
  parameter int          WIDTH = 16,
  parameter logic [15:0] TAPS  = 16'hB400,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             advance,
  output logic [WIDTH-1:0] state
);

  logic [WIDTH-1:0] nextState;

  always_comb begin
    nextState = state >> 1;
    if (state[0]) nextState = nextState ^ TAPS[WIDTH-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)        state <= SEED[WIDTH-1:0];
    else if (advance) state <= nextState;
  end

  // R6: a maximal-length sequence never visits the all-zero state
  a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);

endmodule

// File: rtl/ssDatapath.sv
module ssDatapath
  import ss_timer_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int LFSR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic [BASE_W-1:0] baseVal,
  input  logic [2:0]        devCode,
  output logic              lastTick
);

  localparam int CNT_W = BASE_W + 1;
  localparam logic [CNT_W-1:0] TARGET_RST = CNT_W'(40);

  logic [LFSR_W-1:0] rnd;
  logic [OFF_W-1:0]  rawOff;
  logic [OFF_W-1:0]  limOff;
  logic [OFF_W-1:0]  offset;
  logic [BASE_W-1:0] baseEff;
  logic [CNT_W-1:0]  nextTarget;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  target;

  ssLfsr #(.WIDTH(LFSR_W)) i_rnd (
    .clk     (clk),
    .rstN    (rstN),
    .advance (strb.load | strb.wrap),
    .state   (rnd)
  );

  // fold the random bits into 0..limit with one compare and one subtract
  always_comb begin
    limOff = devLimit(devCode);
    case (devCode)
      3'd1:      rawOff = OFF_W'(rnd[4:0]);
      3'd2:      rawOff = OFF_W'(rnd[5:0]);
      3'd3, 3'd4: rawOff = rnd[OFF_W-1:0];
      default:   rawOff = '0;
    endcase
    offset = (rawOff > limOff) ? rawOff - (limOff + OFF_W'(1)) : rawOff;
  end

  assign baseEff    = (baseVal == '0) ? BASE_W'(1) : baseVal;
  assign nextTarget = CNT_W'(baseEff) + CNT_W'(offset);
  assign lastTick   = (count == target - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      target <= TARGET_RST;
    end else if (strb.clear) begin
      count  <= '0;
    end else if (strb.load || strb.wrap) begin
      count  <= '0;
      target <= nextTarget;
    end else if (strb.step) begin
      count  <= count + CNT_W'(1);
    end
  end

  // R2: the counter never runs past the end of its period
  a_r2_count_below_target: assert property (@(posedge clk) disable iff (!rstN)
    count < target);

  // R4: the drawn offset stays within the active code's limit
  a_r4_offset_bound: assert property (@(posedge clk) disable iff (!rstN)
    offset <= devLimit(devCode));

  // R5: reserved and zero codes draw no extra ticks
  a_r5_no_spread_codes: assert property (@(posedge clk) disable iff (!rstN)
    (devCode == 3'd0 || devCode > 3'd4) |-> offset == '0);

  // R3: a new period is never shorter than the effective base
  a_r3_target_floor: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load || strb.wrap) |=> target >= CNT_W'($past(baseEff)));

endmodule

// File: rtl/ssCtrl.sv
module ssCtrl
  import ss_timer_pkg::*;
#(
  parameter int               BASE_W   = 8,
  parameter logic [BASE_W-1:0] BASE_RST = 8'h28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              enable,
  input  logic              start,
  input  logic              cfgWrite,
  input  logic              cfgSel,
  input  logic [7:0]        cfgData,
  input  logic              lastTick,
  output seqStrobes_t       strb,
  output logic [BASE_W-1:0] baseReg,
  output logic [2:0]        devReg,
  output logic              bitPulse
);

  logic running;
  logic startOk;

  assign startOk = start && enable;

  always_comb begin
    strb = '0;
    if (cfgWrite)                       strb.clear = 1'b1;
    else if (startOk)                   strb.load  = 1'b1;
    else if (running && enable && tick) begin
      if (lastTick) strb.wrap = 1'b1;
      else          strb.step = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg  <= BASE_RST;
      devReg   <= 3'd0;
      running  <= 1'b0;
      bitPulse <= 1'b0;
    end else begin
      bitPulse <= strb.wrap;
      if (cfgWrite) begin
        running <= 1'b0;
        if (cfgSel) devReg  <= cfgData[2:0];
        else        baseReg <= BASE_W'(cfgData);
      end else if (startOk) begin
        running <= 1'b1;
      end else if (!enable) begin
        running <= 1'b0;
      end
    end
  end

  // R8: dropping enable silences the output on the next cycle
  a_r8_disable_silences: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !bitPulse);

  // R9: a register write stops the run
  a_r9_write_aborts: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> (!running && !bitPulse));

  // R10: a write beside a start leaves the run stopped
  a_r10_write_beats_start: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && start) |=> !running);

  // R7: a boundary pulse only comes out of an active run
  a_r7_pulse_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    bitPulse |-> $past(running));

  // R7: an accepted start leaves the run active
  a_r7_start_runs: assert property (@(posedge clk) disable iff (!rstN)
    (startOk && !cfgWrite) |=> running);

endmodule

// File: rtl/ssBitTimer.sv
module ssBitTimer
  import ss_timer_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int LFSR_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       enable,
  input  logic       start,
  input  logic       cfgWrite,
  input  logic       cfgSel,
  input  logic [7:0] cfgData,
  output logic       bitPulse
);

  seqStrobes_t       strb;
  logic [BASE_W-1:0] baseReg;
  logic [2:0]        devReg;
  logic              lastTick;

  ssCtrl #(.BASE_W(BASE_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .enable   (enable),
    .start    (start),
    .cfgWrite (cfgWrite),
    .cfgSel   (cfgSel),
    .cfgData  (cfgData),
    .lastTick (lastTick),
    .strb     (strb),
    .baseReg  (baseReg),
    .devReg   (devReg),
    .bitPulse (bitPulse)
  );

  ssDatapath #(.BASE_W(BASE_W), .LFSR_W(LFSR_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .baseVal  (baseReg),
    .devCode  (devReg),
    .lastTick (lastTick)
  );

endmodule

// File: tb/test_ssBitTimer.sv
module test_ssBitTimer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b1;
  logic       enable = 1'b0;
  logic       start = 1'b0;
  logic       cfgWrite = 1'b0;
  logic       cfgSel = 1'b0;
  logic [7:0] cfgData = 8'h00;
  logic       bitPulse;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ssBitTimer i_ssBitTimer (
    .clk(clk), .rstN(rstN), .tick(tick), .enable(enable), .start(start),
    .cfgWrite(cfgWrite), .cfgSel(cfgSel), .cfgData(cfgData), .bitPulse(bitPulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input bit sel, input logic [7:0] data);
    @(negedge clk);
    cfgWrite = 1'b1; cfgSel = sel; cfgData = data;
    @(posedge clk); #1;
    cfgWrite = 1'b0;
  endtask

  task automatic doStart();
    @(negedge clk);
    start = 1'b1; enable = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  // counts pulses over n cycles with tick held high
  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(posedge clk); #1;
      if (bitPulse) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  // measures nPer periods right after a start, tick every div cycles
  task automatic measure(input string req, input int div, input int nPer,
                         input int lo, input int hi, output int mn, output int mx);
    int last = 0;
    int got = 0;
    int limit = nPer * (hi + 1) * div + 10;
    mn = 1 << 30; mx = -1;
    for (int idx = 1; idx <= limit && got < nPer; idx++) begin
      @(negedge clk); tick = ((idx % div) == 0);
      @(posedge clk); #1;
      if (bitPulse) begin
        int ticks = (idx - last) / div;
        check((idx - last) % div == 0 && ticks >= lo && ticks <= hi, req, ticks, lo);
        if (ticks < mn) mn = ticks;
        if (ticks > mx) mx = ticks;
        last = idx;
        got++;
      end
    end
    @(negedge clk); tick = 1'b1;
    check(got == nPer, req, got, nPer);
  endtask

  task automatic t_reset();
    int mn, mx;
    check(bitPulse == 1'b0, "R1", int'(bitPulse), 0);
    doStart();
    measure("R1", 1, 3, 40, 40, mn, mx);
  endtask

  task automatic t_exact();
    int mn, mx;
    writeReg(1'b0, 8'd13);
    writeReg(1'b1, 8'd0);
    doStart();
    measure("R3", 1, 5, 13, 13, mn, mx);
    doStart();
    measure("R2", 3, 4, 13, 13, mn, mx);
    writeReg(1'b0, 8'd0);
    doStart();
    measure("R3", 2, 6, 1, 1, mn, mx);
  endtask

  task automatic t_spread();
    int mn, mx;
    int lims[4] = '{16, 32, 64, 78};
    writeReg(1'b0, 8'd10);
    for (int c = 1; c <= 4; c++) begin
      writeReg(1'b1, 8'(c));
      doStart();
      measure("R4", 1, 60, 10, 10 + lims[c-1], mn, mx);
      check(mx > mn, "R6", mx, mn + 1);
      if (c >= 3) check(mx > 26, "R4", mx, 27);
    end
  endtask

  task automatic t_reserved();
    int mn, mx;
    writeReg(1'b0, 8'd9);
    for (int c = 5; c <= 7; c++) begin
      writeReg(1'b1, 8'(c));
      doStart();
      measure("R5", 1, 8, 9, 9, mn, mx);
    end
  endtask

  task automatic t_restart();
    int mn, mx;
    writeReg(1'b1, 8'd0);
    writeReg(1'b0, 8'd40);
    doStart();
    quiet(25, "R7");
    doStart();
    measure("R7", 1, 1, 40, 40, mn, mx);
    writeReg(1'b0, 8'd12);
    @(negedge clk); enable = 1'b0; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    quiet(60, "R7");
  endtask

  task automatic t_disable();
    writeReg(1'b0, 8'd20);
    doStart();
    quiet(10, "R8");
    @(negedge clk); enable = 1'b0;
    quiet(100, "R8");
  endtask

  task automatic t_abort();
    int mn, mx;
    writeReg(1'b0, 8'd40);
    doStart();
    quiet(15, "R9");
    writeReg(1'b0, 8'd6);
    quiet(80, "R9");
    doStart();
    measure("R9", 1, 2, 6, 6, mn, mx);
    doStart();
    quiet(3, "R9");
    writeReg(1'b1, 8'd0);
    quiet(30, "R9");
  endtask

  task automatic t_collide();
    int mn, mx;
    writeReg(1'b0, 8'd40);
    doStart();
    @(negedge clk);
    cfgWrite = 1'b1; cfgSel = 1'b0; cfgData = 8'd7; start = 1'b1;
    @(posedge clk); #1;
    cfgWrite = 1'b0; start = 1'b0;
    quiet(60, "R10");
    doStart();
    measure("R10", 1, 2, 7, 7, mn, mx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    t_reset();
    t_exact();
    t_spread();
    t_reserved();
    t_restart();
    t_disable();
    t_abort();
    t_collide();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule